// File: doc/BRIEF.md
# DRAM Power-Up and CAS-First Refresh Scheduler

This block brings an asynchronous DRAM out of power-up and then keeps its contents alive. Right after reset it holds both strobes high through a start-up wait. It then runs a burst of initialization refresh cycles on its own, because no access can be in flight before it reports `ready`. From then on an interval timer creates one refresh slot every `REF_INTERVAL` clocks. The interval is chosen so the device's whole row set is visited within its retention period. Every refresh cycle lowers the column strobe first and the row strobe afterwards. The device therefore takes the row from its own internal counter, and no address, write enable or output enable is driven.

In normal operation the scheduler shares the strobes with an access controller through a request/grant pair. A refresh never interrupts an access: the scheduler raises `ref_req` and waits. It drives the strobes only after `ref_gnt` arrives. The controller keeps `ref_gnt` high for as long as `ref_req` stays high. Slots that arrive while the grant is held back are counted, up to `PEND_MAX`. All counted slots are then run back to back under the same request. A slot that arrives while the count is already full is lost and sets the sticky `ovf_err` flag.

The controlling state machine has six states:
- PWRUP: the start-up wait.
- IDLE: no slot is pending.
- REQ: the request is raised and the grant is awaited.
- CAS: the column strobe is low and the row strobe is still high.
- RAS: both strobes are low.
- PRE: both strobes are high for precharge.

Its transitions are:
- PWRUP→CAS when the start-up timer expires.
- IDLE→REQ when a slot is pending.
- REQ→CAS on grant.
- CAS→RAS after `CSR_CYC` clocks.
- RAS→PRE after `RAS_CYC` clocks. This transition retires one slot, or one init cycle before `ready`.
- PRE→CAS when more init cycles remain, or when a slot is still pending.
- PRE→IDLE otherwise. The first PRE→IDLE transition sets `ready`.

Top module: `dram_refresh_sched`

## Requirements
- R1: While `rst_n` is low, `ras_n` and `cas_n` are 1 and `ref_req`, `ready` and `ovf_err` are 0. Reset is asynchronous and clears all state, including `ovf_err`.
- R2: After reset release, both strobes stay high for `STARTUP_CYC` clocks. `cas_n` falls in the `STARTUP_CYC`-th clock after release.
- R3: Before `ready`, exactly `INIT_CNT` refresh cycles run back to back, and `ref_req` stays 0 throughout.
- R4: `ready` rises `RP_CYC` clocks after the row strobe rises at the end of the last init cycle. Once high, it stays high until reset.
- R5: Every refresh cycle holds `cas_n` low with `ras_n` high for exactly `CSR_CYC` clocks before `ras_n` falls. `cas_n` stays low for the whole time `ras_n` is low.
- R6: `ras_n` stays low for exactly `RAS_CYC` clocks per cycle. Both strobes are high for at least `RP_CYC` clocks before the next column strobe fall.
- R7: Refresh slots occur every `REF_INTERVAL` clocks, counted from `ready`. With the grant answered at once, `ref_req` first rises `REF_INTERVAL`+1 clocks after `ready`. Successive requests are then `REF_INTERVAL` clocks apart.
- R8: `ref_req` rises with both strobes high. It stays high with both strobes high for as long as `ref_gnt` is low.
- R9: One grant covers every pending slot: the cycles run back to back. `ref_req` falls when no slot remains, so the pulse count equals the number of pending slots, at most `PEND_MAX`.
- R10: A slot that arrives while `PEND_MAX` slots are already pending and none retires is lost. It sets `ovf_err`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Grant from the access controller; held while `ref_req` is high |
| ref_req | output | 1 | Request for the strobe lines |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| ready | output | 1 | Initialization finished; normal accesses allowed |
| ovf_err | output | 1 | Sticky: a refresh slot was lost |

## Verification
The grant delay is the stimulus that matters. A grant answered at once shows one pulse per request at the plain interval spacing. Delays that span one or two further slots show that the backlog is drained back to back, with the pulse count following the backlog. A delay that spans three further slots saturates the counter, and the sticky error separates a full queue from an overflowing one. The start-up, init burst and strobe-order timing are measured on every cycle the block issues.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_REQ,
        ST_CAS,
        ST_RAS,
        ST_PRE
    } ref_state_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_ref_tick.sv
// Free-running interval timer, enabled once initialization is finished.
module dram_ref_tick #(
    parameter int REF_INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(REF_INTERVAL + 1);
    localparam logic [CW-1:0] LAST = CW'(REF_INTERVAL - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!en)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = en && (cnt == LAST);
endmodule

// File: rtl/dram_ref_pend.sv
// Saturating count of refresh slots owed to the device.
module dram_ref_pend #(
    parameter int PEND_MAX = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic pend_nz,
    output logic ovf
);
    localparam int PW = $clog2(PEND_MAX + 1);
    localparam logic [PW-1:0] FULL = PW'(PEND_MAX);

    logic [PW-1:0] pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
            ovf  <= 1'b0;
        end else if (inc && !dec) begin
            if (pend == FULL)
                ovf <= 1'b1;
            else
                pend <= pend + 1'b1;
        end else if (dec && !inc) begin
            pend <= pend - 1'b1;
        end
    end

    assign pend_nz = (pend != '0);
endmodule

// File: rtl/dram_ref_seq.sv
// Strobe sequencer: power-up wait, init burst, granted refresh cycles.
module dram_ref_seq
    import dram_ref_pkg::*;
#(
    parameter int STARTUP_CYC = 10000,
    parameter int INIT_CNT    = 8,
    parameter int CSR_CYC     = 1,
    parameter int RAS_CYC     = 6,
    parameter int RP_CYC      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pend_nz,
    input  logic gnt,
    output logic ras_n,
    output logic cas_n,
    output logic req,
    output logic ready,
    output logic done
);
    localparam int TMAX  = max_of(max_of(STARTUP_CYC, CSR_CYC), max_of(RAS_CYC, RP_CYC));
    localparam int TMR_W = $clog2(TMAX + 1);
    localparam int IW    = $clog2(INIT_CNT + 1);
    localparam logic [TMR_W-1:0] SU_LD  = TMR_W'(STARTUP_CYC - 1);
    localparam logic [TMR_W-1:0] CSR_LD = TMR_W'(CSR_CYC - 1);
    localparam logic [TMR_W-1:0] RAS_LD = TMR_W'(RAS_CYC - 1);
    localparam logic [TMR_W-1:0] RP_LD  = TMR_W'(RP_CYC - 1);

    ref_state_t       st, st_n;
    logic [TMR_W-1:0] tmr, tmr_n;
    logic [IW-1:0]    init_left, init_n;
    logic             rdy_n;
    logic             expired;

    assign expired = (tmr == '0);

    always_comb begin
        st_n   = st;
        tmr_n  = expired ? tmr : tmr - 1'b1;
        init_n = init_left;
        rdy_n  = ready;
        unique case (st)
            ST_PWRUP: if (expired) begin
                st_n  = ST_CAS;
                tmr_n = CSR_LD;
            end
            ST_IDLE: if (pend_nz) st_n = ST_REQ;
            ST_REQ: if (gnt) begin
                st_n  = ST_CAS;
                tmr_n = CSR_LD;
            end
            ST_CAS: if (expired) begin
                st_n  = ST_RAS;
                tmr_n = RAS_LD;
            end
            ST_RAS: if (expired) begin
                st_n  = ST_PRE;
                tmr_n = RP_LD;
                if (!ready) init_n = init_left - 1'b1;
            end
            ST_PRE: if (expired) begin
                if (!ready) begin
                    if (init_left == '0) begin
                        st_n  = ST_IDLE;
                        rdy_n = 1'b1;
                    end else begin
                        st_n  = ST_CAS;
                        tmr_n = CSR_LD;
                    end
                end else if (pend_nz) begin
                    st_n  = ST_CAS;
                    tmr_n = CSR_LD;
                end else begin
                    st_n = ST_IDLE;
                end
            end
            default: st_n = ST_PWRUP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= ST_PWRUP;
            tmr       <= SU_LD;
            init_left <= IW'(INIT_CNT);
            ready     <= 1'b0;
        end else begin
            st        <= st_n;
            tmr       <= tmr_n;
            init_left <= init_n;
            ready     <= rdy_n;
        end
    end

    always_comb begin
        cas_n = !((st == ST_CAS) || (st == ST_RAS));
        ras_n = !(st == ST_RAS);
        req   = ready && ((st == ST_REQ) || (st == ST_CAS) ||
                          (st == ST_RAS) || (st == ST_PRE));
        done  = ready && (st == ST_RAS) && expired;
    end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
    parameter int STARTUP_CYC  = 10000,
    parameter int INIT_CNT     = 8,
    parameter int REF_INTERVAL = 1560,
    parameter int PEND_MAX     = 4,
    parameter int CSR_CYC      = 1,
    parameter int RAS_CYC      = 6,
    parameter int RP_CYC       = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_gnt,
    output logic ref_req,
    output logic ras_n,
    output logic cas_n,
    output logic ready,
    output logic ovf_err
);
    logic tick, pend_nz, done;

    dram_ref_tick #(.REF_INTERVAL(REF_INTERVAL)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(ready), .tick(tick)
    );

    dram_ref_pend #(.PEND_MAX(PEND_MAX)) u_pend (
        .clk(clk), .rst_n(rst_n), .inc(tick), .dec(done),
        .pend_nz(pend_nz), .ovf(ovf_err)
    );

    dram_ref_seq #(
        .STARTUP_CYC(STARTUP_CYC), .INIT_CNT(INIT_CNT),
        .CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .pend_nz(pend_nz), .gnt(ref_gnt),
        .ras_n(ras_n), .cas_n(cas_n), .req(ref_req), .ready(ready), .done(done)
    );
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
    parameter int RAS_CYC = 6
) (
    input logic clk,
    input logic rst_n,
    input logic ref_gnt,
    input logic ref_req,
    input logic ras_n,
    input logic cas_n,
    input logic ready,
    input logic ovf_err
);
    int unsigned ras_lo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ras_lo <= 0;
        else if (!ras_n)
            ras_lo <= ras_lo + 1;
        else
            ras_lo <= 0;
    end

    // R5
    ras_under_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n);

    // R5
    cas_leads_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> ($past(cas_n) == 1'b0));

    // R6
    ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (ras_lo == RAS_CYC));

    // R3
    quiet_before_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !ref_req);

    // R4
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);

    // R8
    req_idle_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_req) |-> (cas_n && ras_n));

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_gnt) |=> ref_req);
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(.RAS_CYC(RAS_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .ras_n(ras_n), .cas_n(cas_n), .ready(ready), .ovf_err(ovf_err)
);

// File: tb/dram_refresh_sched_test.sv
module dram_refresh_sched_test;
    localparam int CLK_PERIOD = 10;
    localparam int STARTUP = 20;
    localparam int INIT    = 8;
    localparam int INTV    = 40;
    localparam int PMAX    = 3;
    localparam int CSR     = 2;
    localparam int RASC    = 4;
    localparam int RP      = 3;
    localparam int NVEC    = 6;

    typedef struct packed {
        logic [15:0] dly;
        logic [15:0] pulses;
        logic        err;
    } vec_t;

    // grant delay after request, RAS pulses under that grant, error flag after
    localparam vec_t VECS [NVEC] = '{
        '{16'd0,   16'd1, 1'b0},
        '{16'd0,   16'd1, 1'b0},
        '{16'd45,  16'd2, 1'b0},
        '{16'd5,   16'd1, 1'b0},
        '{16'd85,  16'd3, 1'b0},
        '{16'd125, 16'd3, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_gnt = 1'b0;
    logic ref_req, ras_n, cas_n, ready, ovf_err;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dram_refresh_sched #(
        .STARTUP_CYC(STARTUP), .INIT_CNT(INIT), .REF_INTERVAL(INTV),
        .PEND_MAX(PMAX), .CSR_CYC(CSR), .RAS_CYC(RASC), .RP_CYC(RP)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
        .ras_n(ras_n), .cas_n(cas_n), .ready(ready), .ovf_err(ovf_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Strobe-shape monitor (R5, R6)
    logic pr = 1'b1, pc = 1'b1;
    int cpre = 0, hi = 0, lo = 0, hi_last = 0;
    bit overlap_bad = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            pr = 1'b1; pc = 1'b1; cpre = 0; hi = 0; lo = 0; hi_last = 0;
            overlap_bad = 1'b0;
        end else begin
            if (pc && !cas_n) hi_last = hi;
            if (!ras_n && pr) begin
                check(cpre == CSR, "R5 cas-first lead", cpre, CSR);
                check(hi_last >= RP, "R6 precharge before cycle", hi_last, RP);
            end
            if (!ras_n && cas_n) overlap_bad = 1'b1;
            if (ras_n && !pr) begin
                check(lo == RASC, "R6 ras low width", lo, RASC);
                check(!overlap_bad, "R5 cas low during ras", int'(overlap_bad), 0);
                overlap_bad = 1'b0;
            end
            cpre = (!cas_n && ras_n) ? cpre + 1 : 0;
            hi   = (ras_n && cas_n) ? hi + 1 : 0;
            lo   = (!ras_n) ? lo + 1 : 0;
            pr = ras_n;
            pc = cas_n;
        end
    end

    initial begin
        int n, falls, pulses;
        bit prv, req_seen, quiet, rdy_drop;
        time rise_t, prev_t;

        repeat (3) @(negedge clk);
        // R1 reset state
        check({ras_n, cas_n, ref_req, ready, ovf_err} == 5'b11000, "R1 reset outputs",
              int'({ras_n, cas_n, ref_req, ready, ovf_err}), 5'b11000);

        rst_n = 1'b1;
        n = 0;
        quiet = 1'b1;
        do begin
            @(negedge clk);
            n++;
            if (!ras_n) quiet = 1'b0;
        end while (cas_n && n < 10 * STARTUP);
        // R2 start-up wait
        check(n == STARTUP, "R2 first cas fall", n, STARTUP);
        check(quiet, "R2 ras idle during wait", int'(quiet), 1);

        // R3 init burst, R4 ready timing
        falls = 0; prv = ras_n; req_seen = 1'b0; rise_t = $time;
        while (!ready) begin
            @(negedge clk);
            if (!ras_n && prv) falls++;
            if (ras_n && !prv) rise_t = $time;
            if (ref_req) req_seen = 1'b1;
            prv = ras_n;
        end
        check(falls == INIT, "R3 init cycle count", falls, INIT);
        check(!req_seen, "R3 no request during init", int'(req_seen), 0);
        check(int'(($time - rise_t) / CLK_PERIOD) == RP, "R4 ready after last precharge",
              int'(($time - rise_t) / CLK_PERIOD), RP);

        // R7 first request
        n = 0;
        while (!ref_req) begin
            @(negedge clk);
            n++;
        end
        check(n == INTV + 1, "R7 first request delay", n, INTV + 1);

        prev_t = $time;
        rdy_drop = 1'b0;
        for (int v = 0; v < NVEC; v++) begin
            while (!ref_req) begin
                @(negedge clk);
                if (!ready) rdy_drop = 1'b1;
            end
            if (v > 0 && VECS[v-1].dly == 0)
                check(int'(($time - prev_t) / CLK_PERIOD) == INTV, "R7 request spacing",
                      int'(($time - prev_t) / CLK_PERIOD), INTV);
            prev_t = $time;
            quiet = 1'b1;
            for (int d = 0; d < int'(VECS[v].dly); d++) begin
                @(negedge clk);
                if (!ref_req || !cas_n || !ras_n) quiet = 1'b0;
            end
            check(quiet, "R8 wait for grant", int'(quiet), 1);
            ref_gnt = 1'b1;
            pulses = 0;
            prv = ras_n;
            while (ref_req) begin
                @(negedge clk);
                if (!ras_n && prv) pulses++;
                prv = ras_n;
            end
            ref_gnt = 1'b0;
            check(pulses == int'(VECS[v].pulses), "R9 pulses per grant", pulses,
                  int'(VECS[v].pulses));
            check(ovf_err == VECS[v].err, "R10 overflow flag", int'(ovf_err),
                  int'(VECS[v].err));
        end
        check(!rdy_drop && ready, "R4 ready stays high", int'(ready), 1);

        // R10 sticky across later slots
        repeat (INTV + 2) @(negedge clk);
        check(ovf_err == 1'b1, "R10 error sticky", int'(ovf_err), 1);

        // R1 reset mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        check({ras_n, cas_n, ref_req, ready, ovf_err} == 5'b11000, "R1 reset mid-run",
              int'({ras_n, cas_n, ref_req, ready, ovf_err}), 5'b11000);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R9 watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule